// File: doc/BRIEF.md
# SPI Slave with Address Filtering

This block is the serial core of an SPI slave. It receives and sends 8-bit or 9-bit characters in SPI mode 0 (MOSI sampled on the rising SCK edge, MISO changed on the falling edge, MSB first). The serial pins are sampled in the system clock domain, so SCK must be several times slower than `clk_i`. Received characters go into a small receive buffer. Transmit characters are written through a data port.

In address-frame format, the first character after SS falls is taken as an address. It is checked against two programmed values. One of three match rules applies: a masked compare, either of two addresses, or an inclusive range. When the address does not match, the rest of the frame is discarded.

Software can switch the receiver on and off while the core runs, and turning it off flushes the buffer. When preload is on, a data write made while SS is idle goes straight into the transmit shift register. A falling SS edge can raise a one-cycle wake pulse.

Top module: `spi_addr_slave`

## Requirements
- R1: The character length is 9 bits when `chsize_i` is 1 and 8 bits for every other code (0, and the reserved codes 2 to 7). MOSI is sampled on each rising SCK edge while SS is low, MSB first. A received 8-bit character appears with bit 8 at zero.
- R2: MISO shows the MSB of the active character in the transmit shift register, and the register shifts on each falling SCK edge. A data write made while preload is off is held, and it loads at the next SS fall. At the falling edge after the last bit of a character, the next held value loads, or all zeros if none is held.
- R3: Address mode 0 matches when the low 8 bits of the address character equal `addr_a_i` in every bit where `addr_b_i` is 0. Bits where `addr_b_i` is 1 are ignored.
- R4: Address mode 1 matches when the address equals `addr_a_i` or `addr_b_i`.
- R5: Address mode 2 matches when `addr_b_i <= address <= addr_a_i`, with both limits included. Address mode 3 never matches.
- R6: With `addr_frame_i` high, the first character of a frame is the address. On a match, the address and the rest of the frame are stored. On a mismatch, nothing from the frame is stored and the overflow flag does not change. With `addr_frame_i` low, every character is stored.
- R7: The receive buffer holds 2 characters, read out in arrival order. A character that completes while the buffer is full is dropped and sets `rx_ovf_o`. The flag stays set until the receiver is disabled.
- R8: Writing 0 to the receiver enable clears `rx_en_o`, empties the buffer and clears `rx_ovf_o`, all from the next cycle. Characters that complete while the receiver is off are not stored.
- R9: Both `rx_en_o` and `rx_busy_o` reset to 0. Writing 1 while `core_en_i` is low sets `rx_en_o` on the next cycle. Writing 1 while `core_en_i` is high raises `rx_busy_o` on the next cycle. After SYNC_CYCLES (2) cycles in total, busy drops and `rx_en_o` rises.
- R10: With `preload_en_i` high and SS high, a data write goes straight into the transmit shift register, so MISO shows its MSB on the next cycle.
- R11: With `ss_wake_en_i` high, a falling SS edge gives a one-cycle `wake_o` pulse on the cycle after the edge is sampled. With it low, no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| core_en_i | input | 1 | Core enabled; gates serial activity and selects the enable timing |
| chsize_i | input | 3 | Character size code |
| addr_frame_i | input | 1 | Address-frame format select |
| amode_i | input | 2 | Address match mode |
| addr_a_i | input | 8 | Address / upper limit |
| addr_b_i | input | 8 | Mask / second address / lower limit |
| preload_en_i | input | 1 | Transmit preload while SS idle |
| ss_wake_en_i | input | 1 | Wake on SS falling edge |
| rx_en_wr_i | input | 1 | Receiver enable write strobe |
| rx_en_wdata_i | input | 1 | Receiver enable write value |
| rx_en_o | output | 1 | Receiver enabled |
| rx_busy_o | output | 1 | Receiver enable pending |
| tx_wr_i | input | 1 | Transmit data write strobe |
| tx_data_i | input | 9 | Transmit data |
| rx_rd_i | input | 1 | Pop one receive character |
| rx_data_o | output | 9 | Oldest received character |
| rx_valid_o | output | 1 | Receive buffer not empty |
| rx_ovf_o | output | 1 | Receive overflow flag |
| wake_o | output | 1 | Wake pulse |
| sck_i | input | 1 | Serial clock |
| mosi_i | input | 1 | Serial data in |
| ss_ni | input | 1 | Slave select, active low |
| miso_o | output | 1 | Serial data out |

## Verification
The address filter is tried with directed addresses on and just past each limit: the mask edges, both members of the address pair, and the range ends one below and one above. This separates an inclusive compare from an exclusive one and shows which register acts as the upper limit. Random frames then draw the address from either register or from a free value, across all four modes and both character sizes. A match stores exactly the address and data characters, and a mismatch leaves the buffer empty with no overflow. Frames sent without address format, with three characters, or with the receiver off separate plain storage from overflow and from gated reception.

// File: rtl/spi_as_pkg.sv
package spi_as_pkg;
  typedef enum logic [1:0] {
    AM_MASK  = 2'd0,
    AM_PAIR  = 2'd1,
    AM_RANGE = 2'd2,
    AM_RSVD  = 2'd3
  } amode_e;
endpackage

// File: rtl/spi_as_shift.sv
module spi_as_shift #(
  parameter int unsigned CHAR_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              len_max_i,
  input  logic              preload_i,
  input  logic              sck_i,
  input  logic              mosi_i,
  input  logic              ss_ni,
  input  logic              tx_wr_i,
  input  logic [CHAR_W-1:0] tx_data_i,
  output logic              miso_o,
  output logic              ss_fall_o,
  output logic              char_vld_o,
  output logic [CHAR_W-1:0] char_o
);
  localparam int unsigned CNT_W = $clog2(CHAR_W + 1);
  localparam logic [CHAR_W-1:0] SHORT_MASK = {1'b0, {(CHAR_W-1){1'b1}}};

  logic              sck_q, ss_q;
  logic [CNT_W-1:0]  bit_cnt;
  logic [CHAR_W-1:0] rx_sr, tx_sr, hold_q;
  logic              hold_vld, load_pend;
  logic              active, sck_rise, sck_fall, last_bit;
  logic [CHAR_W-1:0] rx_next;

  assign active    = en_i & ~ss_ni;
  assign sck_rise  = active & sck_i & ~sck_q;
  assign sck_fall  = active & ~sck_i & sck_q;
  assign ss_fall_o = ss_q & ~ss_ni;
  assign last_bit  = (bit_cnt == (len_max_i ? CNT_W'(CHAR_W-1) : CNT_W'(CHAR_W-2)));
  assign rx_next   = {rx_sr[CHAR_W-2:0], mosi_i};
  assign miso_o    = len_max_i ? tx_sr[CHAR_W-1] : tx_sr[CHAR_W-2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= 1'b0;
      ss_q  <= 1'b1;
    end else begin
      sck_q <= sck_i;
      ss_q  <= ss_ni;
    end
  end

  // receive side
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt    <= '0;
      rx_sr      <= '0;
      char_vld_o <= 1'b0;
      char_o     <= '0;
    end else begin
      char_vld_o <= 1'b0;
      if (ss_ni) begin
        bit_cnt <= '0;
      end else if (sck_rise) begin
        rx_sr <= rx_next;
        if (last_bit) begin
          bit_cnt    <= '0;
          char_vld_o <= 1'b1;
          char_o     <= len_max_i ? rx_next : (rx_next & SHORT_MASK);
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  // transmit side
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sr     <= '0;
      hold_q    <= '0;
      hold_vld  <= 1'b0;
      load_pend <= 1'b0;
    end else begin
      if (ss_fall_o && hold_vld) begin
        tx_sr    <= hold_q;
        hold_vld <= 1'b0;
      end else if (sck_fall) begin
        if (load_pend) begin
          tx_sr     <= hold_vld ? hold_q : '0;
          hold_vld  <= 1'b0;
          load_pend <= 1'b0;
        end else begin
          tx_sr <= {tx_sr[CHAR_W-2:0], 1'b0};
        end
      end
      if (sck_rise && last_bit) load_pend <= 1'b1;
      if (ss_ni) load_pend <= 1'b0;
      if (tx_wr_i) begin
        if (preload_i && ss_ni) begin
          tx_sr <= tx_data_i;
        end else begin
          hold_q   <= tx_data_i;
          hold_vld <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_as_filter.sv
module spi_as_filter
  import spi_as_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ss_idle_i,
  input  logic              char_vld_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              addr_frame_i,
  input  logic [1:0]        amode_i,
  input  logic [ADDR_W-1:0] addr_a_i,
  input  logic [ADDR_W-1:0] addr_b_i,
  input  logic              rx_en_i,
  output logic              push_o
);
  logic first_q, drop_q, hit;
  amode_e mode;

  assign mode = amode_e'(amode_i);

  always_comb begin
    unique case (mode)
      AM_MASK:  hit = (((addr_i ^ addr_a_i) & ~addr_b_i) == '0);
      AM_PAIR:  hit = (addr_i == addr_a_i) || (addr_i == addr_b_i);
      AM_RANGE: hit = (addr_i <= addr_a_i) && (addr_i >= addr_b_i);
      default:  hit = 1'b0;
    endcase
  end

  assign push_o = char_vld_i & rx_en_i & ((addr_frame_i & first_q) ? hit : ~drop_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q <= 1'b1;
      drop_q  <= 1'b0;
    end else if (ss_idle_i) begin
      first_q <= 1'b1;
      drop_q  <= 1'b0;
    end else if (char_vld_i) begin
      if (addr_frame_i && first_q) drop_q <= ~hit;
      first_q <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_as_rx_fifo.sv
module spi_as_rx_fifo #(
  parameter int unsigned W     = 9,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         valid_o,
  output logic         ovf_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic [CNT_W-1:0] cnt;
  logic             full, do_pop, do_push;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt == CNT_W'(DEPTH));
  assign valid_o = (cnt != '0);
  assign do_pop  = pop_i & valid_o;
  assign do_push = push_i & (~full | do_pop);
  assign data_o  = mem[rd_ptr];

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem[wr_ptr] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
      ovf_o  <= 1'b0;
    end else if (flush_i) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
      ovf_o  <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      if (push_i && !do_push) ovf_o <= 1'b1;
      unique case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/spi_addr_slave.sv
module spi_addr_slave #(
  parameter int unsigned CHAR_W      = 9,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned RX_DEPTH    = 2,
  parameter int unsigned SYNC_CYCLES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              core_en_i,
  input  logic [2:0]        chsize_i,
  input  logic              addr_frame_i,
  input  logic [1:0]        amode_i,
  input  logic [ADDR_W-1:0] addr_a_i,
  input  logic [ADDR_W-1:0] addr_b_i,
  input  logic              preload_en_i,
  input  logic              ss_wake_en_i,
  input  logic              rx_en_wr_i,
  input  logic              rx_en_wdata_i,
  output logic              rx_en_o,
  output logic              rx_busy_o,
  input  logic              tx_wr_i,
  input  logic [CHAR_W-1:0] tx_data_i,
  input  logic              rx_rd_i,
  output logic [CHAR_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              rx_ovf_o,
  output logic              wake_o,
  input  logic              sck_i,
  input  logic              mosi_i,
  input  logic              ss_ni,
  output logic              miso_o
);
  localparam int unsigned SYNC_W = $clog2(SYNC_CYCLES + 1);

  logic              len_max, ss_fall, char_vld, push, flush;
  logic [CHAR_W-1:0] char_d;
  logic [SYNC_W-1:0] sync_cnt;

  assign len_max = (chsize_i == 3'd1);
  assign flush   = rx_en_wr_i & ~rx_en_wdata_i;

  // receiver enable with pending state while core runs
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_en_o   <= 1'b0;
      rx_busy_o <= 1'b0;
      sync_cnt  <= '0;
    end else if (rx_en_wr_i) begin
      if (!rx_en_wdata_i) begin
        rx_en_o   <= 1'b0;
        rx_busy_o <= 1'b0;
      end else if (!core_en_i) begin
        rx_en_o   <= 1'b1;
        rx_busy_o <= 1'b0;
      end else if (!rx_en_o && !rx_busy_o) begin
        rx_busy_o <= 1'b1;
        sync_cnt  <= SYNC_W'(SYNC_CYCLES - 1);
      end
    end else if (rx_busy_o) begin
      if (sync_cnt == '0) begin
        rx_busy_o <= 1'b0;
        rx_en_o   <= 1'b1;
      end else begin
        sync_cnt <= sync_cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wake_o <= 1'b0;
    else         wake_o <= ss_wake_en_i & ss_fall;
  end

  spi_as_shift #(.CHAR_W(CHAR_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (core_en_i),
    .len_max_i  (len_max),
    .preload_i  (preload_en_i),
    .sck_i      (sck_i),
    .mosi_i     (mosi_i),
    .ss_ni      (ss_ni),
    .tx_wr_i    (tx_wr_i),
    .tx_data_i  (tx_data_i),
    .miso_o     (miso_o),
    .ss_fall_o  (ss_fall),
    .char_vld_o (char_vld),
    .char_o     (char_d)
  );

  spi_as_filter #(.ADDR_W(ADDR_W)) u_filter (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ss_idle_i    (ss_ni),
    .char_vld_i   (char_vld),
    .addr_i       (char_d[ADDR_W-1:0]),
    .addr_frame_i (addr_frame_i),
    .amode_i      (amode_i),
    .addr_a_i     (addr_a_i),
    .addr_b_i     (addr_b_i),
    .rx_en_i      (rx_en_o),
    .push_o       (push)
  );

  spi_as_rx_fifo #(.W(CHAR_W), .DEPTH(RX_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush),
    .push_i  (push),
    .data_i  (char_d),
    .pop_i   (rx_rd_i),
    .data_o  (rx_data_o),
    .valid_o (rx_valid_o),
    .ovf_o   (rx_ovf_o)
  );
endmodule

// File: rtl/spi_as_checker.sv
module spi_as_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic core_en_i,
  input logic ss_wake_en_i,
  input logic ss_ni,
  input logic rx_en_wr_i,
  input logic rx_en_wdata_i,
  input logic rx_en_o,
  input logic rx_busy_o,
  input logic rx_valid_o,
  input logic rx_ovf_o,
  input logic wake_o
);
  AST_WAKE_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> ($past(ss_wake_en_i) && !$past(ss_ni))); // R11

  AST_BUSY_ONLY_RUNNING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_busy_o) |-> $past(core_en_i)); // R9

  AST_OVF_NEEDS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_ovf_o) |-> $past(rx_valid_o)); // R7

  AST_OFF_FLUSHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_en_wr_i && !rx_en_wdata_i) |=> (!rx_en_o && !rx_valid_o && !rx_ovf_o)); // R8

  AST_NO_STORE_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_en_o && !rx_valid_o) |=> !rx_valid_o); // R8
endmodule

bind spi_addr_slave spi_as_checker u_chk (.*);

// File: tb/spi_addr_slave_tb_top.sv
`timescale 1ns/1ps
module spi_addr_slave_tb_top;
  localparam int H = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic core_en = 0, addr_frame = 0, preload = 0, wake_en = 0;
  logic [2:0] chsize = 0;
  logic [1:0] amode = 0;
  logic [7:0] addr_a = 0, addr_b = 0;
  logic rx_en_wr = 0, rx_en_wdata = 0, tx_wr = 0, rx_rd = 0;
  logic [8:0] tx_data = 0;
  logic sck = 0, mosi = 0, ss_n = 1;
  logic rx_en, rx_busy, rx_valid, rx_ovf, wake, miso;
  logic [8:0] rx_data;
  int n_tests = 0, n_fail = 0;
  logic [8:0] fr_tx [4];
  logic [8:0] fr_rx [4];

  always #4 clk = ~clk;

  spi_addr_slave dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .core_en_i(core_en), .chsize_i(chsize),
    .addr_frame_i(addr_frame), .amode_i(amode), .addr_a_i(addr_a), .addr_b_i(addr_b),
    .preload_en_i(preload), .ss_wake_en_i(wake_en), .rx_en_wr_i(rx_en_wr),
    .rx_en_wdata_i(rx_en_wdata), .rx_en_o(rx_en), .rx_busy_o(rx_busy),
    .tx_wr_i(tx_wr), .tx_data_i(tx_data), .rx_rd_i(rx_rd), .rx_data_o(rx_data),
    .rx_valid_o(rx_valid), .rx_ovf_o(rx_ovf), .wake_o(wake),
    .sck_i(sck), .mosi_i(mosi), .ss_ni(ss_n), .miso_o(miso)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_hit(input int m, input logic [7:0] a, b, x);
    case (m)
      0: return ((x & ~b) == (a & ~b));
      1: return (x == a) || (x == b);
      2: return (x >= b) && (x <= a);
      default: return 1'b0;
    endcase
  endfunction

  task automatic wr_rxen(input logic v);
    rx_en_wr = 1; rx_en_wdata = v; tick(1); rx_en_wr = 0;
  endtask

  task automatic wr_tx(input logic [8:0] d);
    tx_wr = 1; tx_data = d; tick(1); tx_wr = 0;
  endtask

  task automatic xfer(input logic [8:0] d, input int len, output logic [8:0] got);
    got = '0;
    for (int i = len - 1; i >= 0; i--) begin
      mosi = d[i]; tick(H);
      got[i] = miso;
      sck = 1; tick(H); sck = 0;
    end
  endtask

  task automatic run_frame(input int n, input int len);
    ss_n = 0; tick(H);
    for (int i = 0; i < n; i++) xfer(fr_tx[i], len, fr_rx[i]);
    tick(H); ss_n = 1; tick(H + 2);
  endtask

  task automatic pop_chk(input string req, input logic [8:0] exp);
    chk(req, {31'd0, rx_valid}, 32'd1);
    chk(req, {23'd0, rx_data}, {23'd0, exp});
    rx_rd = 1; tick(1); rx_rd = 0;
  endtask

  task automatic addr_test(input string req, input int len, input logic [8:0] ac,
                           input logic [8:0] dc, input bit hit);
    fr_tx[0] = ac; fr_tx[1] = dc;
    run_frame(2, len);
    if (hit) begin
      pop_chk(req, ac);
      pop_chk(req, dc);
    end
    chk(req, {31'd0, rx_valid}, 32'd0);
    chk(req, {31'd0, rx_ovf}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    tick(5); rst_ni = 1; tick(2);
    // R9 reset state
    chk("R9 reset rx_en", {31'd0, rx_en}, 0);
    chk("R9 reset busy", {31'd0, rx_busy}, 0);
    chk("R7 reset ovf", {31'd0, rx_ovf}, 0);
    chk("R11 reset wake", {31'd0, wake}, 0);

    // R9 immediate enable while core disabled
    wr_rxen(1);
    chk("R9 immediate enable", {31'd0, rx_en}, 1);
    chk("R9 no busy", {31'd0, rx_busy}, 0);
    core_en = 1;

    // R1/R2 9-bit characters, held tx data loaded at SS fall, then zeros
    chsize = 3'd1;
    wr_tx(9'h1C3);
    fr_tx[0] = 9'h1A5; fr_tx[1] = 9'h0FF;
    run_frame(2, 9);
    chk("R2 miso char0", {23'd0, fr_rx[0]}, 32'h1C3);
    chk("R2 miso char1 zeros", {23'd0, fr_rx[1]}, 0);
    pop_chk("R1 9-bit first", 9'h1A5);
    pop_chk("R1 9-bit second", 9'h0FF);

    // R1 reserved code acts as 8 bits
    chsize = 3'd5;
    fr_tx[0] = 9'h0C3;
    run_frame(1, 8);
    pop_chk("R1 reserved size 8-bit", 9'h0C3);
    chsize = 3'd0;

    // R7 overflow and R8 flush
    fr_tx[0] = 9'h011; fr_tx[1] = 9'h022; fr_tx[2] = 9'h033;
    run_frame(3, 8);
    chk("R7 ovf set", {31'd0, rx_ovf}, 1);
    pop_chk("R7 oldest kept", 9'h011);
    pop_chk("R7 second kept", 9'h022);
    chk("R7 newest dropped", {31'd0, rx_valid}, 0);
    chk("R7 ovf sticky", {31'd0, rx_ovf}, 1);
    fr_tx[0] = 9'h044;
    run_frame(1, 8);
    wr_rxen(0);
    chk("R8 rx_en off", {31'd0, rx_en}, 0);
    chk("R8 flushed", {31'd0, rx_valid}, 0);
    chk("R8 ovf cleared", {31'd0, rx_ovf}, 0);
    fr_tx[0] = 9'h055; fr_tx[1] = 9'h066;
    run_frame(2, 8);
    chk("R8 off not stored", {31'd0, rx_valid}, 0);

    // R9 enable while core running
    wr_rxen(1);
    chk("R9 busy cycle1", {31'd0, rx_busy}, 1);
    chk("R9 not yet enabled", {31'd0, rx_en}, 0);
    tick(1);
    chk("R9 busy cycle2", {31'd0, rx_busy}, 1);
    tick(1);
    chk("R9 busy dropped", {31'd0, rx_busy}, 0);
    chk("R9 enabled", {31'd0, rx_en}, 1);

    // address modes
    addr_frame = 1;
    amode = 2'd0; addr_a = 8'hA0; addr_b = 8'h0F;
    addr_test("R3 mask hit", 8, 9'h0A7, 9'h011, 1);
    addr_test("R3 mask miss", 8, 9'h0B0, 9'h012, 0);
    amode = 2'd1; addr_a = 8'h12; addr_b = 8'h34;
    addr_test("R4 first addr", 8, 9'h012, 9'h0AA, 1);
    addr_test("R4 second addr", 8, 9'h034, 9'h0BB, 1);
    fr_tx[2] = 9'h0CC;
    fr_tx[0] = 9'h056; fr_tx[1] = 9'h0CC;
    run_frame(3, 8);
    chk("R6 miss drops frame", {31'd0, rx_valid}, 0);
    chk("R6 miss no ovf", {31'd0, rx_ovf}, 0);
    amode = 2'd2; addr_a = 8'h40; addr_b = 8'h20;
    addr_test("R5 lower limit", 8, 9'h020, 9'h001, 1);
    addr_test("R5 upper limit", 8, 9'h040, 9'h002, 1);
    addr_test("R5 above", 8, 9'h041, 9'h003, 0);
    addr_test("R5 below", 8, 9'h01F, 9'h004, 0);
    amode = 2'd3; addr_a = 8'h30; addr_b = 8'h30;
    addr_test("R5 reserved mode", 8, 9'h030, 9'h005, 0);

    // R6 random frames
    for (int it = 0; it < 30; it++) begin
      int m, sel, len;
      logic [7:0] x;
      logic [8:0] ac, dc;
      m = int'($urandom % 4);
      addr_a = 8'($urandom); addr_b = 8'($urandom);
      sel = int'($urandom % 3);
      x = (sel == 0) ? addr_a : (sel == 1) ? addr_b : 8'($urandom);
      len = ($urandom % 2 == 1) ? 9 : 8;
      chsize = (len == 9) ? 3'd1 : 3'd0;
      amode = 2'(m);
      ac = {(len == 9) ? 1'($urandom) : 1'b0, x};
      dc = 9'($urandom);
      if (len == 8) dc[8] = 1'b0;
      addr_test("R6 random", len, ac, dc, exp_hit(m, addr_a, addr_b, x));
    end
    addr_frame = 0; chsize = 3'd0;

    // R10 preload
    preload = 1;
    wr_tx(9'h0A5);
    chk("R10 preload msb1", {31'd0, miso}, 1);
    wr_tx(9'h05A);
    chk("R10 preload msb0", {31'd0, miso}, 0);
    preload = 0;
    wr_tx(9'h0A5);
    chk("R2 held not shown", {31'd0, miso}, 0);
    ss_n = 0; tick(2);
    chk("R2 held at ss fall", {31'd0, miso}, 1);
    ss_n = 1; tick(3);
    preload = 1;
    wr_tx(9'h03C);
    fr_tx[0] = 9'h000;
    run_frame(1, 8);
    chk("R10 preload sent", {23'd0, fr_rx[0]}, 32'h03C);
    rx_rd = 1; tick(1); rx_rd = 0;
    preload = 0;

    // R11 wake
    wake_en = 1;
    ss_n = 0; tick(1);
    chk("R11 wake pulse", {31'd0, wake}, 1);
    tick(1);
    chk("R11 wake one cycle", {31'd0, wake}, 0);
    ss_n = 1; tick(3);
    wake_en = 0;
    ss_n = 0; tick(1);
    chk("R11 no wake disabled", {31'd0, wake}, 0);
    ss_n = 1; tick(3);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule